// File: doc/BRIEF.md
# Cascaded Interrupt Aggregator

This block gathers a set of interrupt request lines (24 by default) into a single combined interrupt line for a host processor. Each request passes through a synchronizer and then one of two paths. Most sources are edge-sensitive: a rising edge is latched into a pending bit, but only while that source is enabled. A single source, chosen by a parameter, is level-sensitive: its status bit tracks the synchronized input level and is never latched.

Software reaches the block over a plain byte-wide register bus with an address, a read strobe, a write strobe and an 8-bit write data input. It sees one status byte and one enable byte for each group of eight sources. Reading a status byte acknowledges all edge-sensitive sources in that group. No separate acknowledge write is needed. The combined output is high while any source has both its status bit and its enable bit set. The host samples this output as a rising-edge event.

Top module: `cascade_irq_agg`

## Requirements
- R1: After reset, the combined output is 0, the read data output is 0, and all three enable bytes read back as 0.
- R2: Enable bytes are written and read at address 3 (sources 0–7), address 4 (sources 8–15) and address 5 (sources 16–23). Bit n of a byte belongs to source 8·group+n. A 1 enables the source.
- R3: The combined output is 1 exactly when some source has both its status bit and its enable bit at 1, in any group. It changes in the cycle in which a status or enable bit changes.
- R4: A rising edge on an enabled edge-sensitive input sets that source's status bit. The combined output rises after the third clock edge that follows the input change: two synchronizer stages, then the latch.
- R5: A rising edge that arrives while the source is disabled is lost. Enabling the source afterwards does not raise its status bit or the combined output.
- R6: Status bytes are read at address 0 (sources 0–7), address 1 (sources 8–15) and address 2 (sources 16–23). Read data appears on the clock edge that samples the read strobe and is valid for the following cycle. The value returned is the status before the read. The read clears every edge-sensitive status bit of that group only.
- R7: If a new enabled edge on a source is latched on the same clock edge as a read of its status byte, that status bit stays 1. The read returns the value from before that edge.
- R8: The level-sensitive source (index 5 by default) has a status bit equal to its synchronized input level, whether or not it is enabled. A status read does not clear it. It reaches the combined output only when enabled.
- R9: Writes to status addresses 0–2 have no effect. Reads of unused addresses 6 and 7 return 0.
- R10: An edge-sensitive input that is held high produces a single event. Once its status is cleared by a read, the status stays 0 until the input falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | 24 | Asynchronous interrupt request inputs |
| busAddr | input | 3 | Register address |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| irqOut | output | 1 | Combined interrupt toward the host |

## Verification
The bench targets four kinds of mistake:
- **Edge arriving on the read's clock edge.** A design that lets the clear win over a new edge drops that event, and the second read comes back empty.
- **Edge arriving while disabled.** A design that latches the raw edge regardless of enable raises the interrupt as soon as software enables the source.
- **Read-clear scope.** A design that clears across groups, or that clears the level source, loses pending bits in a neighbouring byte or drops a level request that is still asserted.
- **Held-high inputs and ignored accesses.** A design that latches levels instead of edges re-raises the status after every read. The bench also checks that writes to status addresses are ignored and that unused addresses read as zero.

// File: rtl/cascade_irq_pkg.sv
package cascade_irq_pkg;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned GRP_W  = 3;
  localparam int unsigned BYTE_W = 8;

  // Strobes passed from the bus decoder to the datapath
  typedef struct packed {
    logic             rdStrobe;
    logic             wrStrobe;
    logic             hit;
    logic             isMask;
    logic [GRP_W-1:0] grp;
  } busStrobe_t;

endpackage

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import cascade_irq_pkg::*;
#(
  parameter int unsigned NUM_GRP = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  output busStrobe_t        strb
);

  localparam int unsigned MAP_END = 2 * NUM_GRP;

  int unsigned addrInt;

  always_comb begin
    addrInt       = int'(busAddr);
    strb.rdStrobe = busRd;
    strb.wrStrobe = busWr;
    strb.hit      = addrInt < MAP_END;
    strb.isMask   = addrInt >= NUM_GRP;
    if (strb.isMask) strb.grp = GRP_W'(addrInt - NUM_GRP);
    else             strb.grp = GRP_W'(addrInt);
  end

endmodule

// File: rtl/cascade_irq_dp.sv
module cascade_irq_dp
  import cascade_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 24,
  parameter int unsigned LEVEL_SRC   = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  busStrobe_t         strb,
  input  logic [BYTE_W-1:0]  busWdata,
  output logic [BYTE_W-1:0]  busRdata,
  output logic [NUM_SRC-1:0] statusVec,
  output logic [NUM_SRC-1:0] maskVec,
  output logic [NUM_SRC-1:0] riseVec,
  output logic               irqOut
);

  localparam int unsigned NUM_GRP = NUM_SRC / BYTE_W;

  logic [NUM_SRC-1:0] syncQ [SYNC_STAGES];
  logic [NUM_SRC-1:0] syncOut;
  logic [NUM_SRC-1:0] prevQ;
  logic [NUM_SRC-1:0] pendQ;
  logic [NUM_SRC-1:0] pendNext;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] clrVec;
  logic [NUM_SRC-1:0] setVec;
  logic [BYTE_W-1:0]  rdByte;

  // Synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < int'(SYNC_STAGES); s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= reqIn;
      for (int s = 1; s < int'(SYNC_STAGES); s++) syncQ[s] <= syncQ[s-1];
    end
  end

  assign syncOut = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncOut;
  end

  assign riseVec = syncOut & ~prevQ;

  // Per-group clear on status read
  always_comb begin
    clrVec = '0;
    for (int g = 0; g < int'(NUM_GRP); g++) begin
      if (strb.rdStrobe && strb.hit && !strb.isMask && strb.grp == GRP_W'(g))
        clrVec[g*BYTE_W +: BYTE_W] = '1;
    end
  end

  assign setVec   = riseVec & maskQ;
  assign pendNext = (pendQ & ~clrVec) | setVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= pendNext;
  end

  // Status: latched edge bits, plus one pass-through level bit
  for (genvar i = 0; i < int'(NUM_SRC); i++) begin : gStatus
    if (i == int'(LEVEL_SRC)) begin : gLevel
      assign statusVec[i] = syncOut[i];
    end else begin : gEdge
      assign statusVec[i] = pendQ[i];
    end
  end

  // Enable registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
    end else begin
      for (int g = 0; g < int'(NUM_GRP); g++) begin
        if (strb.wrStrobe && strb.hit && strb.isMask && strb.grp == GRP_W'(g))
          maskQ[g*BYTE_W +: BYTE_W] <= busWdata;
      end
    end
  end

  assign maskVec = maskQ;

  // Read mux and registered read data
  always_comb begin
    rdByte = '0;
    for (int g = 0; g < int'(NUM_GRP); g++) begin
      if (strb.hit && strb.grp == GRP_W'(g))
        rdByte = strb.isMask ? maskQ[g*BYTE_W +: BYTE_W] : statusVec[g*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              busRdata <= '0;
    else if (strb.rdStrobe) busRdata <= rdByte;
  end

  assign irqOut = |(statusVec & maskQ);

endmodule

// File: rtl/cascade_irq_agg.sv
module cascade_irq_agg
  import cascade_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 24,
  parameter int unsigned LEVEL_SRC   = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busRd,
  input  logic               busWr,
  input  logic [BYTE_W-1:0]  busWdata,
  output logic [BYTE_W-1:0]  busRdata,
  output logic               irqOut
);

  localparam int unsigned NUM_GRP = NUM_SRC / BYTE_W;

  busStrobe_t         strb;
  logic [NUM_SRC-1:0] statusVec;
  logic [NUM_SRC-1:0] maskVec;
  logic [NUM_SRC-1:0] riseVec;

  cascade_irq_ctrl #(.NUM_GRP(NUM_GRP)) uCtrl (
    .busAddr(busAddr),
    .busRd  (busRd),
    .busWr  (busWr),
    .strb   (strb)
  );

  cascade_irq_dp #(
    .NUM_SRC    (NUM_SRC),
    .LEVEL_SRC  (LEVEL_SRC),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .reqIn    (reqIn),
    .strb     (strb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .statusVec(statusVec),
    .maskVec  (maskVec),
    .riseVec  (riseVec),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/cascade_irq_chk.sv
module cascade_irq_chk #(
  parameter int unsigned NUM_SRC   = 24,
  parameter int unsigned LEVEL_SRC = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic [2:0]         busAddr,
  input logic               busRd,
  input logic               busWr,
  input logic [7:0]         busWdata,
  input logic [7:0]         busRdata,
  input logic [NUM_SRC-1:0] statusVec,
  input logic [NUM_SRC-1:0] maskVec,
  input logic [NUM_SRC-1:0] riseVec,
  input logic               irqOut
);

  localparam logic [NUM_SRC-1:0] EDGE_BITS = ~(NUM_SRC'(1) << LEVEL_SRC);

  // R6: status read data shows the pre-read status one edge later
  a_r6_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == 3'd0) |=> busRdata == $past(statusVec[7:0]));

  // R6, R7: after a group-0 read only freshly latched edges remain set
  a_r6_clear_on_read: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == 3'd0) |=>
      ((statusVec[7:0] & EDGE_BITS[7:0]) & ~$past(riseVec[7:0] & maskVec[7:0])) == 8'h00);

  // R5: an edge bit that is clear and disabled stays clear
  a_r5_masked_edge_lost: assert property (@(posedge clk) disable iff (!rstN)
    ($past(~statusVec & ~maskVec) & statusVec & EDGE_BITS) == '0);

  // R3: nothing enabled means no combined interrupt
  a_r3_quiet_when_masked: assert property (@(posedge clk) disable iff (!rstN)
    (maskVec == '0) |-> !irqOut);

  // R2: an enable-byte write lands in the addressed group
  a_r2_mask_write: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 3'd4) |=> maskVec[15:8] == $past(busWdata));

endmodule

bind cascade_irq_agg cascade_irq_chk #(
  .NUM_SRC  (NUM_SRC),
  .LEVEL_SRC(LEVEL_SRC)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busRd    (busRd),
  .busWr    (busWr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .statusVec(statusVec),
  .maskVec  (maskVec),
  .riseVec  (riseVec),
  .irqOut   (irqOut)
);

// File: tb/sim_cascade_irq_agg.sv
module sim_cascade_irq_agg;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] reqIn = '0;
  logic [2:0]  busAddr = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic        irqOut;

  int testCount = 0;
  int failCount = 0;

  always #2 clk = ~clk;

  cascade_irq_agg u0 (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .busAddr(busAddr),
    .busRd(busRd), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic tReset();
    logic [7:0] v;
    check("R1 rdata", busRdata, 8'h00);
    check("R1 irq", {7'd0, irqOut}, 8'h00);
    for (int a = 3; a < 6; a++) begin
      busRead(3'(a), v);
      check("R1 mask reset", v, 8'h00);
    end
  endtask

  task automatic tMaskRw();
    logic [7:0] v;
    busWrite(3'd3, 8'hA5); busWrite(3'd4, 8'h3C); busWrite(3'd5, 8'h81);
    busRead(3'd3, v); check("R2 mask0", v, 8'hA5);
    busRead(3'd4, v); check("R2 mask1", v, 8'h3C);
    busRead(3'd5, v); check("R2 mask2", v, 8'h81);
    busWrite(3'd3, 8'h00); busWrite(3'd4, 8'h00); busWrite(3'd5, 8'h00);
  endtask

  task automatic tEdge();
    logic [7:0] v;
    busWrite(3'd3, 8'h01);
    reqIn[0] = 1'b1;
    waitCyc(2);
    check("R4 not yet", {7'd0, irqOut}, 8'h00);
    waitCyc(1);
    check("R4 irq after 3 edges", {7'd0, irqOut}, 8'h01);
    busRead(3'd0, v);
    check("R6 status value", v, 8'h01);
    check("R6 irq cleared", {7'd0, irqOut}, 8'h00);
    waitCyc(3);
    busRead(3'd0, v);
    check("R10 held high one event", v, 8'h00);
    reqIn[0] = 1'b0;
    busWrite(3'd3, 8'h00);
    waitCyc(3);
  endtask

  task automatic tMaskedLost();
    logic [7:0] v;
    reqIn[1] = 1'b1;
    waitCyc(4);
    check("R5 no irq while masked", {7'd0, irqOut}, 8'h00);
    busWrite(3'd3, 8'h02);
    waitCyc(2);
    check("R5 no irq after enable", {7'd0, irqOut}, 8'h00);
    busRead(3'd0, v);
    check("R5 status empty", v, 8'h00);
    reqIn[1] = 1'b0;
    busWrite(3'd3, 8'h00);
    waitCyc(3);
  endtask

  task automatic tGroupClear();
    logic [7:0] v;
    busWrite(3'd3, 8'h80); busWrite(3'd4, 8'h01);
    reqIn[7] = 1'b1; reqIn[8] = 1'b1;
    waitCyc(4);
    busRead(3'd0, v);
    check("R6 grp0 status", v, 8'h80);
    check("R3 grp1 still drives irq", {7'd0, irqOut}, 8'h01);
    busRead(3'd1, v);
    check("R6 grp1 untouched by grp0 read", v, 8'h01);
    check("R3 irq drops", {7'd0, irqOut}, 8'h00);
    reqIn[7] = 1'b0; reqIn[8] = 1'b0;
    busWrite(3'd3, 8'h00); busWrite(3'd4, 8'h00);
    waitCyc(3);
  endtask

  task automatic tCollision();
    logic [7:0] v;
    busWrite(3'd5, 8'h06);
    reqIn[17] = 1'b1;
    waitCyc(4);
    reqIn[18] = 1'b1;
    waitCyc(2);
    busRead(3'd2, v);
    check("R7 read returns old status", v, 8'h02);
    busRead(3'd2, v);
    check("R7 colliding edge kept", v, 8'h04);
    reqIn[17] = 1'b0; reqIn[18] = 1'b0;
    busWrite(3'd5, 8'h00);
    waitCyc(3);
  endtask

  task automatic tLevel();
    logic [7:0] v;
    reqIn[5] = 1'b1;
    waitCyc(3);
    check("R8 disabled level no irq", {7'd0, irqOut}, 8'h00);
    busRead(3'd0, v);
    check("R8 level status", v, 8'h20);
    busRead(3'd0, v);
    check("R8 level not cleared", v, 8'h20);
    busWrite(3'd3, 8'h20);
    check("R3 enabled level irq", {7'd0, irqOut}, 8'h01);
    reqIn[5] = 1'b0;
    waitCyc(3);
    check("R8 level follows input", {7'd0, irqOut}, 8'h00);
    busRead(3'd0, v);
    check("R8 level status low", v, 8'h00);
    busWrite(3'd3, 8'h00);
  endtask

  task automatic tIgnored();
    logic [7:0] v;
    busWrite(3'd3, 8'h04);
    reqIn[2] = 1'b1;
    waitCyc(4);
    busWrite(3'd0, 8'h00);
    check("R9 status write ignored irq", {7'd0, irqOut}, 8'h01);
    busRead(3'd0, v);
    check("R9 status write ignored", v, 8'h04);
    busRead(3'd6, v);
    check("R9 addr6 zero", v, 8'h00);
    busRead(3'd7, v);
    check("R9 addr7 zero", v, 8'h00);
    reqIn[2] = 1'b0;
    busWrite(3'd3, 8'h00);
    waitCyc(3);
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    tReset();
    tMaskRw();
    tEdge();
    tMaskedLost();
    tGroupClear();
    tCollision();
    tLevel();
    tIgnored();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    testCount++;
    failCount++;
    $display("FAIL watchdog expired");
    finishRun();
  end

endmodule